// File: doc/BRIEF.md
# Pipeline hazard and operand-bypass controller

This block is the hazard logic for a five-stage in-order pipeline. The stages are fetch, decode with register read, execute, memory and writeback. The logic is purely combinational. Each cycle it compares the source register numbers held in decode and in execute against the destination numbers and write enables of the instructions further down the pipe.

From those comparisons it drives four groups of outputs:
- the bypass mux selects for both ALU operands;
- the bypass selects for the operands of the branch comparator, which sits in decode;
- hold enables for the program counter and the fetch/decode register;
- a bubble insert for the decode/execute register and a squash for the fetch/decode register.

Branches resolve at the end of decode, so a taken branch costs one wrongly fetched instruction. That instruction is squashed. The catch is that a branch comparison needs its operands one stage earlier than the ALU does. The block therefore also forwards memory-stage ALU results into decode. It stalls a branch whose operand is still being computed in execute, or is still being loaded.

The register file is assumed to write in the first half of the cycle and read in the second. A writeback-to-decode dependency therefore needs no action here.

Top module: `hzd_ctrl`

## Requirements
- R1: Each ALU operand select is 2 bits: 00 selects the register file value, 10 the memory-stage result and 01 the writeback-stage result. A select is 10 when the memory-stage destination equals that execute source, and 01 when only the writeback-stage destination does. With no producing instruction in flight, every output is 0.
- R2: When both the memory-stage and the writeback-stage destinations equal an execute source, that operand's select is 10.
- R3: Register 0 never matches as a bypass source. A destination matches only while its stage's register-write bit is 1.
- R4: When execute holds a load (register-write and memory-to-register both 1) whose nonzero destination equals either decode source, pc_hold, ifid_hold and idex_flush are all 1 for that cycle. Once the load has moved on to memory, these stall outputs drop to 0. One cycle later the consumer in execute takes the loaded value with select 01.
- R5: A decode bypass select is 1 exactly when the memory stage holds a register-writing, non-load instruction whose nonzero destination equals that decode source.
- R6: While id_branch is 1, all three stall outputs are 1 in either of two cases: a register-writing instruction in execute has a nonzero destination equal to a decode source, or a load in memory has a nonzero destination equal to a decode source.
- R7: ifid_flush is 1 only when id_branch and id_taken are both 1 and no stall is raised. id_taken has no effect while id_branch is 0.
- R8: Two dependencies raise no stall and no decode bypass: a writeback-stage destination matching a decode source, and a non-branch in decode that depends on a non-load in execute.
- R9: An instruction writing a register, followed by four instructions that each read it, proceeds with no stall. The dependents take the value with select 10, then 01, then from the register file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | 5 | First source register of the instruction in decode |
| id_rs2 | input | 5 | Second source register of the instruction in decode |
| id_branch | input | 1 | Decode instruction is a conditional branch |
| id_taken | input | 1 | Branch comparator outcome in decode |
| ex_rs1 | input | 5 | First source register of the instruction in execute |
| ex_rs2 | input | 5 | Second source register of the instruction in execute |
| ex_rd | input | 5 | Destination register of the instruction in execute |
| ex_regwrite | input | 1 | Execute instruction writes a register |
| ex_memtoreg | input | 1 | Execute instruction is a load |
| mem_rd | input | 5 | Destination register of the instruction in memory |
| mem_regwrite | input | 1 | Memory-stage instruction writes a register |
| mem_memtoreg | input | 1 | Memory-stage instruction is a load |
| wb_rd | input | 5 | Destination register of the instruction in writeback |
| wb_regwrite | input | 1 | Writeback instruction writes a register |
| ex_fwd_a | output | 2 | Bypass select for ALU operand A |
| ex_fwd_b | output | 2 | Bypass select for ALU operand B |
| id_fwd_a | output | 1 | Branch operand A takes the memory-stage result |
| id_fwd_b | output | 1 | Branch operand B takes the memory-stage result |
| pc_hold | output | 1 | Keep the program counter unchanged |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged |
| ifid_flush | output | 1 | Squash the fetch/decode register (wrong-path fetch) |
| idex_flush | output | 1 | Load a bubble into the decode/execute register |

## Verification
The bench builds the block with its default parameters: 5-bit register numbers and two sources per instruction. That width brings register 0 and the full 32-entry register space within reach.

The table exercises bypass priority, register-0 gating and both kinds of stall at the port boundary. The directed sequences drive the stage contents cycle by cycle. They cover the four-reader chain and the release of a load-use stall.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } alu_sel_e;
endpackage

// File: rtl/hzd_match.sv
module hzd_match #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] dst,
  input  logic          wen,
  output logic          hit
);
  always_comb begin
    hit = wen && (dst != '0) && (dst == src);
  end
endmodule

// File: rtl/hzd_ex_bypass.sv
module hzd_ex_bypass
  import hzd_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0]    src,
  input  logic [AW-1:0]    mem_rd,
  input  logic             mem_wen,
  input  logic [AW-1:0]    wb_rd,
  input  logic             wb_wen,
  output logic [SEL_W-1:0] sel
);
  logic mem_hit;
  logic wb_hit;

  hzd_match #(.AW(AW)) u_mem (.src(src), .dst(mem_rd), .wen(mem_wen), .hit(mem_hit));
  hzd_match #(.AW(AW)) u_wb  (.src(src), .dst(wb_rd),  .wen(wb_wen),  .hit(wb_hit));

  // the newer producer wins
  always_comb begin
    if (mem_hit)     sel = SEL_MEM;
    else if (wb_hit) sel = SEL_WB;
    else             sel = SEL_RF;
  end
endmodule

// File: rtl/hzd_stall.sv
module hzd_stall #(
  parameter int AW   = 5,
  parameter int NSRC = 2
) (
  input  logic [NSRC-1:0][AW-1:0] id_src,
  input  logic                    id_branch,
  input  logic                    id_taken,
  input  logic [AW-1:0]           ex_rd,
  input  logic                    ex_wen,
  input  logic                    ex_load,
  input  logic [AW-1:0]           mem_rd,
  input  logic                    mem_wen,
  input  logic                    mem_load,
  output logic                    stall,
  output logic                    squash
);
  logic [NSRC-1:0] ex_hit;
  logic [NSRC-1:0] mem_ld_hit;
  logic            load_use;
  logic            br_wait;
  logic            mem_ld_wen;

  assign mem_ld_wen = mem_wen & mem_load;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    hzd_match #(.AW(AW)) u_ex (
      .src(id_src[i]), .dst(ex_rd), .wen(ex_wen), .hit(ex_hit[i])
    );
    hzd_match #(.AW(AW)) u_mem (
      .src(id_src[i]), .dst(mem_rd), .wen(mem_ld_wen), .hit(mem_ld_hit[i])
    );
  end

  always_comb begin
    load_use = ex_load && (|ex_hit);
    br_wait  = id_branch && ((|ex_hit) || (|mem_ld_hit));
    stall    = load_use || br_wait;
    squash   = id_branch && id_taken && !stall;
  end
endmodule

// File: rtl/hzd_ctrl.sv
module hzd_ctrl
  import hzd_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] id_rs1,
  input  logic [REG_AW-1:0] id_rs2,
  input  logic              id_branch,
  input  logic              id_taken,
  input  logic [REG_AW-1:0] ex_rs1,
  input  logic [REG_AW-1:0] ex_rs2,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_regwrite,
  input  logic              ex_memtoreg,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_regwrite,
  input  logic              mem_memtoreg,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic              wb_regwrite,
  output logic [SEL_W-1:0]  ex_fwd_a,
  output logic [SEL_W-1:0]  ex_fwd_b,
  output logic              id_fwd_a,
  output logic              id_fwd_b,
  output logic              pc_hold,
  output logic              ifid_hold,
  output logic              ifid_flush,
  output logic              idex_flush
);
  localparam int NSRC = 2;

  logic [NSRC-1:0][REG_AW-1:0] id_src;
  logic [NSRC-1:0][REG_AW-1:0] ex_src;
  logic [NSRC-1:0][SEL_W-1:0]  ex_sel;
  logic [NSRC-1:0]             id_sel;
  logic                        mem_alu_wen;
  logic                        stall;

  assign id_src      = {id_rs2, id_rs1};
  assign ex_src      = {ex_rs2, ex_rs1};
  assign mem_alu_wen = mem_regwrite & ~mem_memtoreg;

  for (genvar i = 0; i < NSRC; i++) begin : g_op
    hzd_ex_bypass #(.AW(REG_AW)) u_exb (
      .src(ex_src[i]), .mem_rd(mem_rd), .mem_wen(mem_regwrite),
      .wb_rd(wb_rd), .wb_wen(wb_regwrite), .sel(ex_sel[i])
    );
    hzd_match #(.AW(REG_AW)) u_idb (
      .src(id_src[i]), .dst(mem_rd), .wen(mem_alu_wen), .hit(id_sel[i])
    );
  end

  hzd_stall #(.AW(REG_AW), .NSRC(NSRC)) u_stall (
    .id_src(id_src), .id_branch(id_branch), .id_taken(id_taken),
    .ex_rd(ex_rd), .ex_wen(ex_regwrite), .ex_load(ex_memtoreg),
    .mem_rd(mem_rd), .mem_wen(mem_regwrite), .mem_load(mem_memtoreg),
    .stall(stall), .squash(ifid_flush)
  );

  assign ex_fwd_a   = ex_sel[0];
  assign ex_fwd_b   = ex_sel[1];
  assign id_fwd_a   = id_sel[0];
  assign id_fwd_b   = id_sel[1];
  assign pc_hold    = stall;
  assign ifid_hold  = stall;
  assign idex_flush = stall;
endmodule

// File: rtl/hzd_ctrl_chk.sv
module hzd_ctrl_chk #(
  parameter int REG_AW = 5
) (
  input logic [REG_AW-1:0] id_rs1,
  input logic [REG_AW-1:0] id_rs2,
  input logic              id_branch,
  input logic              id_taken,
  input logic [REG_AW-1:0] ex_rs1,
  input logic [REG_AW-1:0] ex_rs2,
  input logic [REG_AW-1:0] ex_rd,
  input logic              ex_regwrite,
  input logic              ex_memtoreg,
  input logic [REG_AW-1:0] mem_rd,
  input logic              mem_regwrite,
  input logic              mem_memtoreg,
  input logic [REG_AW-1:0] wb_rd,
  input logic              wb_regwrite,
  input logic [1:0]        ex_fwd_a,
  input logic [1:0]        ex_fwd_b,
  input logic              id_fwd_a,
  input logic              id_fwd_b,
  input logic              pc_hold,
  input logic              ifid_hold,
  input logic              ifid_flush,
  input logic              idex_flush
);
  always_comb begin
    // R1
    sel_legal_chk: assert (ex_fwd_a != 2'b11 && ex_fwd_b != 2'b11);
    // R1
    if (wb_regwrite && wb_rd != '0 && wb_rd == ex_rs1 &&
        !(mem_regwrite && mem_rd == ex_rs1))
      wb_pick_chk: assert (ex_fwd_a == 2'b01);
    // R2
    if (mem_regwrite && mem_rd != '0 && mem_rd == ex_rs2)
      mem_prio_chk: assert (ex_fwd_b == 2'b10);
    // R3
    if (ex_rs1 == '0)
      zero_src_chk: assert (ex_fwd_a == 2'b00);
    // R4
    if (ex_regwrite && ex_memtoreg && ex_rd != '0 &&
        (ex_rd == id_rs1 || ex_rd == id_rs2))
      load_use_chk: assert (pc_hold && ifid_hold && idex_flush);
    // R5
    if (id_fwd_a || id_fwd_b)
      id_byp_src_chk: assert (mem_regwrite && !mem_memtoreg);
    // R7
    flush_excl_chk: assert (!(ifid_flush && ifid_hold));
    // R7
    if (ifid_flush)
      flush_cause_chk: assert (id_branch && id_taken);
  end
endmodule

bind hzd_ctrl hzd_ctrl_chk #(.REG_AW(REG_AW)) u_chk (
  .id_rs1(id_rs1), .id_rs2(id_rs2), .id_branch(id_branch), .id_taken(id_taken),
  .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd), .ex_regwrite(ex_regwrite),
  .ex_memtoreg(ex_memtoreg), .mem_rd(mem_rd), .mem_regwrite(mem_regwrite),
  .mem_memtoreg(mem_memtoreg), .wb_rd(wb_rd), .wb_regwrite(wb_regwrite),
  .ex_fwd_a(ex_fwd_a), .ex_fwd_b(ex_fwd_b), .id_fwd_a(id_fwd_a),
  .id_fwd_b(id_fwd_b), .pc_hold(pc_hold), .ifid_hold(ifid_hold),
  .ifid_flush(ifid_flush), .idex_flush(idex_flush)
);

// File: tb/hzd_ctrl_bench.sv
module hzd_ctrl_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [4:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic       id_branch, id_taken, ex_regwrite, ex_memtoreg;
  logic       mem_regwrite, mem_memtoreg, wb_regwrite;
  logic [1:0] ex_fwd_a, ex_fwd_b;
  logic       id_fwd_a, id_fwd_b, pc_hold, ifid_hold, ifid_flush, idex_flush;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  hzd_ctrl u_hzd_ctrl (
    .id_rs1(id_rs1), .id_rs2(id_rs2), .id_branch(id_branch), .id_taken(id_taken),
    .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd), .ex_regwrite(ex_regwrite),
    .ex_memtoreg(ex_memtoreg), .mem_rd(mem_rd), .mem_regwrite(mem_regwrite),
    .mem_memtoreg(mem_memtoreg), .wb_rd(wb_rd), .wb_regwrite(wb_regwrite),
    .ex_fwd_a(ex_fwd_a), .ex_fwd_b(ex_fwd_b), .id_fwd_a(id_fwd_a),
    .id_fwd_b(id_fwd_b), .pc_hold(pc_hold), .ifid_hold(ifid_hold),
    .ifid_flush(ifid_flush), .idex_flush(idex_flush)
  );

  // stimulus {id_rs1,id_rs2,br,tk, ex_rs1,ex_rs2,ex_rd,ex_rw,ex_ld,
  //           mem_rd,mem_rw,mem_ld, wb_rd,wb_rw} | expect {fa,fb,ia,ib,stall,flush}
  localparam int NV = 14;
  localparam logic [49:0] VEC [NV] = '{
    // 0 R1 idle
    {5'd0,5'd0,1'b0,1'b0, 5'd0,5'd0,5'd0,1'b0,1'b0, 5'd0,1'b0,1'b0, 5'd0,1'b0, 2'b00,2'b00,1'b0,1'b0,1'b0,1'b0},
    // 1 R1 mem for A, wb for B
    {5'd0,5'd0,1'b0,1'b0, 5'd3,5'd4,5'd0,1'b0,1'b0, 5'd3,1'b1,1'b0, 5'd4,1'b1, 2'b10,2'b01,1'b0,1'b0,1'b0,1'b0},
    // 2 R2 both stages match
    {5'd0,5'd0,1'b0,1'b0, 5'd7,5'd7,5'd0,1'b0,1'b0, 5'd7,1'b1,1'b0, 5'd7,1'b1, 2'b10,2'b10,1'b0,1'b0,1'b0,1'b0},
    // 3 R3 register 0
    {5'd0,5'd0,1'b0,1'b0, 5'd0,5'd0,5'd0,1'b0,1'b0, 5'd0,1'b1,1'b0, 5'd0,1'b1, 2'b00,2'b00,1'b0,1'b0,1'b0,1'b0},
    // 4 R3 write enables off
    {5'd0,5'd0,1'b0,1'b0, 5'd9,5'd0,5'd0,1'b0,1'b0, 5'd9,1'b0,1'b0, 5'd9,1'b0, 2'b00,2'b00,1'b0,1'b0,1'b0,1'b0},
    // 5 R4 load-use on source 2
    {5'd0,5'd5,1'b0,1'b0, 5'd0,5'd0,5'd5,1'b1,1'b1, 5'd0,1'b0,1'b0, 5'd0,1'b0, 2'b00,2'b00,1'b0,1'b0,1'b1,1'b0},
    // 6 R4 load without dependent
    {5'd6,5'd8,1'b0,1'b0, 5'd0,5'd0,5'd5,1'b1,1'b1, 5'd0,1'b0,1'b0, 5'd0,1'b0, 2'b00,2'b00,1'b0,1'b0,1'b0,1'b0},
    // 7 R6 R7 branch on ALU result in execute, flush held off
    {5'd10,5'd0,1'b1,1'b1, 5'd0,5'd0,5'd10,1'b1,1'b0, 5'd0,1'b0,1'b0, 5'd0,1'b0, 2'b00,2'b00,1'b0,1'b0,1'b1,1'b0},
    // 8 R6 branch on load in memory
    {5'd0,5'd11,1'b1,1'b0, 5'd0,5'd0,5'd0,1'b0,1'b0, 5'd11,1'b1,1'b1, 5'd0,1'b0, 2'b00,2'b00,1'b0,1'b0,1'b1,1'b0},
    // 9 R5 branch bypass from memory ALU result, taken
    {5'd12,5'd13,1'b1,1'b1, 5'd0,5'd0,5'd0,1'b0,1'b0, 5'd12,1'b1,1'b0, 5'd0,1'b0, 2'b00,2'b00,1'b1,1'b0,1'b0,1'b1},
    // 10 R8 writeback to decode
    {5'd14,5'd0,1'b1,1'b0, 5'd0,5'd0,5'd0,1'b0,1'b0, 5'd0,1'b0,1'b0, 5'd14,1'b1, 2'b00,2'b00,1'b0,1'b0,1'b0,1'b0},
    // 11 R8 non-branch on ALU in execute
    {5'd15,5'd0,1'b0,1'b0, 5'd0,5'd0,5'd15,1'b1,1'b0, 5'd0,1'b0,1'b0, 5'd0,1'b0, 2'b00,2'b00,1'b0,1'b0,1'b0,1'b0},
    // 12 R7 taken branch, no hazard
    {5'd1,5'd2,1'b1,1'b1, 5'd0,5'd0,5'd0,1'b0,1'b0, 5'd0,1'b0,1'b0, 5'd0,1'b0, 2'b00,2'b00,1'b0,1'b0,1'b0,1'b1},
    // 13 R7 taken without branch ignored
    {5'd1,5'd2,1'b0,1'b1, 5'd0,5'd0,5'd0,1'b0,1'b0, 5'd0,1'b0,1'b0, 5'd0,1'b0, 2'b00,2'b00,1'b0,1'b0,1'b0,1'b0}
  };

  function automatic string req_of(int i);
    case (i)
      0, 1:    return "R1";
      2:       return "R2";
      3, 4:    return "R3";
      5, 6:    return "R4";
      7, 8:    return "R6";
      9:       return "R5";
      10, 11:  return "R8";
      default: return "R7";
    endcase
  endfunction

  task automatic drive(input logic [41:0] s);
    {id_rs1, id_rs2, id_branch, id_taken, ex_rs1, ex_rs2, ex_rd, ex_regwrite,
     ex_memtoreg, mem_rd, mem_regwrite, mem_memtoreg, wb_rd, wb_regwrite} = s;
  endtask

  task automatic check(input string req, input logic [7:0] e);
    logic [9:0] act;
    logic [9:0] exp;
    @(negedge clk);
    act = {ex_fwd_a, ex_fwd_b, id_fwd_a, id_fwd_b, pc_hold, ifid_hold, idex_flush, ifid_flush};
    exp = {e[7:2], {3{e[1]}}, e[0]};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: outputs %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(input logic [41:0] s, input string req, input logic [7:0] e);
    @(posedge clk);
    drive(s);
    check(req, e);
  endtask

  initial begin
    drive('0);
    for (int i = 0; i < NV; i++) begin
      @(posedge clk);
      drive(VEC[i][49:8]);
      check(req_of(i), VEC[i][7:0]);
    end

    // R9 writer rd 8 then four readers of register 8
    step({5'd8,5'd0,1'b0,1'b0, 5'd0,5'd0,5'd8,1'b1,1'b0, 5'd0,1'b0,1'b0, 5'd0,1'b0},
         "R9", {2'b00,2'b00,1'b0,1'b0,1'b0,1'b0});
    step({5'd8,5'd0,1'b0,1'b0, 5'd8,5'd0,5'd20,1'b1,1'b0, 5'd8,1'b1,1'b0, 5'd0,1'b0},
         "R9", {2'b10,2'b00,1'b1,1'b0,1'b0,1'b0});
    step({5'd8,5'd0,1'b0,1'b0, 5'd8,5'd0,5'd21,1'b1,1'b0, 5'd20,1'b1,1'b0, 5'd8,1'b1},
         "R9", {2'b01,2'b00,1'b0,1'b0,1'b0,1'b0});
    step({5'd8,5'd0,1'b0,1'b0, 5'd8,5'd0,5'd22,1'b1,1'b0, 5'd21,1'b1,1'b0, 5'd20,1'b1},
         "R9", {2'b00,2'b00,1'b0,1'b0,1'b0,1'b0});

    // R4 load-use stall and its release
    step({5'd5,5'd0,1'b0,1'b0, 5'd0,5'd0,5'd5,1'b1,1'b1, 5'd0,1'b0,1'b0, 5'd0,1'b0},
         "R4", {2'b00,2'b00,1'b0,1'b0,1'b1,1'b0});
    step({5'd5,5'd0,1'b0,1'b0, 5'd0,5'd0,5'd0,1'b0,1'b0, 5'd5,1'b1,1'b1, 5'd0,1'b0},
         "R4", {2'b00,2'b00,1'b0,1'b0,1'b0,1'b0});
    step({5'd0,5'd0,1'b0,1'b0, 5'd5,5'd0,5'd9,1'b1,1'b0, 5'd0,1'b0,1'b0, 5'd5,1'b1},
         "R4", {2'b01,2'b00,1'b0,1'b0,1'b0,1'b0});

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule